// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. An external one-second strobe drives it. Each accepted strobe starts an update cycle. The cycle advances a binary running time, raises an update-in-progress status bit, waits a fixed number of clock cycles, and then copies the time into the readable registers in the encoding chosen by the control register. Software sets the time by freezing updates, writing the time registers and releasing the freeze.

When an update ends, the block compares the encoded seconds, minutes and hours with three alarm registers. An alarm register whose two top bits are both set matches any value. Flags record a finished update and an alarm hit. An enabled event raises the interrupt flag, and the interrupt pin follows that flag. A read strobe on the flag register clears all of the flags.

The update sequencer has three states:
- `ST_IDLE` moves to `ST_WAIT` on an accepted strobe.
- `ST_WAIT` counts `UIP_CYCLES` clock cycles and then moves to `ST_DONE`.
- `ST_DONE` copies the time, evaluates the alarm, sets the flags and returns to `ST_IDLE`.

A strobe is accepted only in `ST_IDLE` and only with the oscillator field set to run.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the registers read as follows. Addresses 0 (seconds), 2 (minutes), 4 (hours) and 9 (year) read 0x00. Addresses 6 (weekday), 7 (day) and 8 (month) read 0x01. Address 10 (control A) reads 0x26, address 11 (control B) reads 0x02 and address 12 (flags) reads 0x00. `irq` is low.
- R2: Seconds wrap from 59 to 0 into minutes, and minutes wrap from 59 to 0 into hours. Hours wrap from 23 to 0 into the next day. Weekday counts 1 to 7 and wraps to 1.
- R3: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days when (2000 + year) is a leap year by the 4/100/400 rule. Month 12 wraps to 1 and increments the year. Year 99 wraps to 0.
- R4: When control B bit 2 is 0, every time field reads as packed BCD, with tens in bits 7:4 and units in bits 3:0. When bit 2 is 1, fields read as plain binary.
- R5: When control B bit 1 is 1, hours read in 24-hour form. When bit 1 is 0, hours read as a value from 0 to 11 with bit 7 set for PM (hour 12 or later).
- R6: Time advances only when control A bits 6:4 equal 3'b010. Any other value makes a strobe have no effect.
- R7: Control A bit 7 goes to 1 on the clock after an accepted strobe if SET (B bit 7) is 0. It stays at 1 for UIP_CYCLES+1 cycles and clears when the registers are refreshed. Software cannot write this bit.
- R8: While SET is 1, updates leave the time registers unchanged and writes to them do not alter the running time. Clearing SET loads the running time from the registers. Writing B with SET set forces B bit 4 (UIE) to 0 and clears control A bit 7.
- R9: When B bit 5 (AIE) is 1 and each of the three alarm registers (1, 3, 5) is either 0xC0-masked or equal to the encoded seconds, minutes or hours, the update sets flag bits 7 and 5.
- R10: Every update sets flag bit 4. When B bit 4 (UIE) is 1, it also sets flag bit 7. `irq` equals flag bit 7.
- R11: A read strobe on address 12 clears all flags and drops `irq`. Writes to address 12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears the flags at address 12) |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt, high while flag bit 7 is set |

## Verification
A wrong running time shows up in the time registers when the first update after the fault finishes, UIP_CYCLES+2 cycles after the strobe. A carry error stays hidden until the field rolls over, so the stimulus loads times within seconds of each rollover boundary in both encodings. A sequencer that is stuck or mistimed shows up at once in control A bit 7 or in a missing update flag. A bad alarm compare shows up in the flag register at the end of the same update.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} upd_state_t;

    localparam int ADR_SEC = 0, ADR_SEC_AL = 1, ADR_MIN = 2, ADR_MIN_AL = 3;
    localparam int ADR_HR = 4, ADR_HR_AL = 5, ADR_DOW = 6, ADR_DOM = 7;
    localparam int ADR_MON = 8, ADR_YR = 9, ADR_CTLA = 10, ADR_CTLB = 11;
    localparam int ADR_FLAGS = 12;
    localparam int B_SET = 7, B_AIE = 5, B_UIE = 4, B_BIN = 2, B_H24 = 1;
    localparam int F_IRQ = 7, F_ALM = 5, F_UPD = 4;

    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [6:0] t;
        logic [6:0] u;
        t = v / 7'd10;
        u = v % 7'd10;
        return bin ? {1'b0, v} : {t[3:0], u[3:0]};
    endfunction

    function automatic logic [6:0] dec_val(input logic [7:0] r, input logic bin);
        return bin ? r[6:0] : (7'(r[7:4]) * 7'd10 + 7'(r[3:0]));
    endfunction

    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                            input logic h24);
        logic [4:0] hh;
        hh = (!h24 && h >= 5'd12) ? h - 5'd12 : h;
        return enc_val({2'b00, hh}, bin) | ((!h24 && h >= 5'd12) ? 8'h80 : 8'h00);
    endfunction

    function automatic logic [4:0] dec_hour(input logic [7:0] r, input logic bin,
                                            input logic h24);
        logic [6:0] b;
        b = dec_val({1'b0, r[6:0]}, bin);
        if (!h24 && r[7]) b = b + 7'd12;
        return b[4:0];
    endfunction

    function automatic logic alarm_ok(input logic [7:0] al, input logic [7:0] v);
        return (al[7:6] == 2'b11) || (al == v);
    endfunction

endpackage

// File: rtl/cal_time_step.sv
module cal_time_step
    import cal_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  cal_time_t cur,
    output cal_time_t nxt
);
    int         yfull;
    logic       leap;
    logic [4:0] dim;

    always_comb begin
        yfull = BASE_YEAR + int'(cur.yr);
        leap  = ((yfull % 4) == 0) && (((yfull % 100) != 0) || ((yfull % 400) == 0));
        case (cur.mon)
            4'd2:                      dim = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   dim = 5'd30;
            default:                   dim = 5'd31;
        endcase
    end

    always_comb begin
        nxt = cur;
        if (cur.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            if (cur.min >= 6'd59) begin
                nxt.min = 6'd0;
                if (cur.hr >= 5'd23) begin
                    nxt.hr  = 5'd0;
                    nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
                    if (cur.dom >= dim) begin
                        nxt.dom = 5'd1;
                        if (cur.mon >= 4'd12) begin
                            nxt.mon = 4'd1;
                            nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
                        end else begin
                            nxt.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        nxt.dom = cur.dom + 5'd1;
                    end
                end else begin
                    nxt.hr = cur.hr + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end
    end
endmodule

// File: rtl/cal_update_fsm.sv
module cal_update_fsm
    import cal_pkg::*;
#(
    parameter int UIP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_ok_i,
    output logic step_o,
    output logic copy_o
);
    localparam int CW = $clog2(UIP_CYCLES) + 1;

    upd_state_t    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (tick_i && run_ok_i) begin
                    state <= ST_WAIT;
                    cnt   <= '0;
                end
                ST_WAIT: if (cnt == CW'(UIP_CYCLES - 1)) state <= ST_DONE;
                         else cnt <= cnt + 1'b1;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        step_o = (state == ST_IDLE) && tick_i && run_ok_i;
        copy_o = (state == ST_DONE);
    end
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int BASE_YEAR  = 2000,
    parameter int UIP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int NREG = ADR_YR + 1;

    logic [7:0] tregs [NREG];
    logic [6:0] ctl_a;
    logic       uip;
    logic [7:0] ctl_b;
    logic [7:0] flags;
    cal_time_t  tm_q, tm_nxt, tm_dec;
    logic       load_pend;
    logic       step, copy;
    logic       bin, h24;
    logic [7:0] e_sec, e_min, e_hr, e_dow, e_dom, e_mon, e_yr;
    logic       al_hit, is_time_wr;

    cal_update_fsm #(.UIP_CYCLES(UIP_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(sec_tick),
        .run_ok_i(ctl_a[6:4] == 3'b010), .step_o(step), .copy_o(copy)
    );

    cal_time_step #(.BASE_YEAR(BASE_YEAR)) u_step (.cur(tm_q), .nxt(tm_nxt));

    always_comb begin
        bin   = ctl_b[B_BIN];
        h24   = ctl_b[B_H24];
        e_sec = enc_val(7'(tm_q.sec), bin);
        e_min = enc_val(7'(tm_q.min), bin);
        e_hr  = enc_hour(tm_q.hr, bin, h24);
        e_dow = enc_val(7'(tm_q.dow), bin);
        e_dom = enc_val(7'(tm_q.dom), bin);
        e_mon = enc_val(7'(tm_q.mon), bin);
        e_yr  = enc_val(tm_q.yr, bin);
        tm_dec.sec = 6'(dec_val(tregs[ADR_SEC], bin));
        tm_dec.min = 6'(dec_val(tregs[ADR_MIN], bin));
        tm_dec.hr  = dec_hour(tregs[ADR_HR], bin, h24);
        tm_dec.dow = 3'(dec_val(tregs[ADR_DOW], bin));
        tm_dec.dom = 5'(dec_val(tregs[ADR_DOM], bin));
        tm_dec.mon = 4'(dec_val(tregs[ADR_MON], bin));
        tm_dec.yr  = dec_val(tregs[ADR_YR], bin);
        al_hit = ctl_b[B_AIE] && alarm_ok(tregs[ADR_SEC_AL], e_sec)
                 && alarm_ok(tregs[ADR_MIN_AL], e_min) && alarm_ok(tregs[ADR_HR_AL], e_hr);
        is_time_wr = (wr_addr <= 4'(ADR_YR)) && (wr_addr != 4'(ADR_SEC_AL))
                     && (wr_addr != 4'(ADR_MIN_AL)) && (wr_addr != 4'(ADR_HR_AL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) tregs[i] <= 8'h00;
            tregs[ADR_DOW] <= 8'h01;
            tregs[ADR_DOM] <= 8'h01;
            tregs[ADR_MON] <= 8'h01;
            ctl_a     <= 7'h26;
            uip       <= 1'b0;
            ctl_b     <= 8'h02;
            flags     <= 8'h00;
            tm_q      <= '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                           hr: 5'd0, min: 6'd0, sec: 6'd0};
            load_pend <= 1'b0;
        end else begin
            load_pend <= 1'b0;
            if (load_pend)  tm_q <= tm_dec;
            else if (step)  tm_q <= tm_nxt;

            if (step && !ctl_b[B_SET]) uip <= 1'b1;
            if (copy) uip <= 1'b0;

            if (copy && !ctl_b[B_SET]) begin
                tregs[ADR_SEC] <= e_sec;
                tregs[ADR_MIN] <= e_min;
                tregs[ADR_HR]  <= e_hr;
                tregs[ADR_DOW] <= e_dow;
                tregs[ADR_DOM] <= e_dom;
                tregs[ADR_MON] <= e_mon;
                tregs[ADR_YR]  <= e_yr;
            end

            flags <= ((rd_en && rd_addr == 4'(ADR_FLAGS)) ? 8'h00 : flags)
                   | (copy ? ((8'h1 << F_UPD)
                             | (al_hit ? ((8'h1 << F_IRQ) | (8'h1 << F_ALM)) : 8'h00)
                             | (ctl_b[B_UIE] ? (8'h1 << F_IRQ) : 8'h00)) : 8'h00);

            if (wr_en) begin
                if (wr_addr <= 4'(ADR_YR)) begin
                    tregs[wr_addr] <= wr_data;
                    if (is_time_wr && !ctl_b[B_SET]) load_pend <= 1'b1;
                end else if (wr_addr == 4'(ADR_CTLA)) begin
                    ctl_a <= wr_data[6:0];
                end else if (wr_addr == 4'(ADR_CTLB)) begin
                    if (wr_data[B_SET]) begin
                        ctl_b <= wr_data & ~(8'h1 << B_UIE);
                        uip   <= 1'b0;
                    end else begin
                        ctl_b <= wr_data;
                        if (ctl_b[B_SET]) load_pend <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        if (rd_addr <= 4'(ADR_YR))           rd_data = tregs[rd_addr];
        else if (rd_addr == 4'(ADR_CTLA))    rd_data = {uip, ctl_a};
        else if (rd_addr == 4'(ADR_CTLB))    rd_data = ctl_b;
        else if (rd_addr == 4'(ADR_FLAGS))   rd_data = flags;
        else                                 rd_data = 8'h00;
        irq = flags[F_IRQ];
    end
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [3:0]  rd_addr,
    input logic        wr_en,
    input logic        uip,
    input logic [7:0]  ctl_b,
    input logic [7:0]  flags,
    input logic [2:0]  div_sel,
    input logic        load_pend,
    input logic [37:0] tm_bits,
    input logic [7:0]  sec_reg,
    input logic        step,
    input logic        copy
);
    p_uip_from_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(step));

    p_halted_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel != 3'b010 && !load_pend) |=> $stable(tm_bits));

    p_frozen_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (copy && ctl_b[7] && !wr_en) |=> $stable(sec_reg));

    p_no_uie_in_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_b[7] |-> !ctl_b[4]);

    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 4'd12 && !copy) |=> (flags == 8'h00));

    p_upd_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> $past(copy));
endmodule

bind cal_clock_core cal_clock_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
    .uip(uip), .ctl_b(ctl_b), .flags(flags), .div_sel(ctl_a[6:4]),
    .load_pend(load_pend), .tm_bits(tm_q), .sec_reg(tregs[0]),
    .step(step), .copy(copy)
);

// File: tb/sim_cal_clock_core.sv
module sim_cal_clock_core;
    localparam int UIP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;
    int         n_run = 0, n_fail = 0, cyc = 0;

    cal_clock_core #(.BASE_YEAR(2000), .UIP_CYCLES(UIP)) u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic int enc(int v, bit bin);
        return bin ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int enc_h(int h, bit bin, bit h24);
        if (h24) return enc(h, bin);
        return enc(h % 12, bin) | ((h >= 12) ? 8'h80 : 0);
    endfunction

    function automatic int dim(int m, int yr);
        int y = 2000 + yr;
        bit lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_addr = 4'(a);
        #1 d = int'(rd_data);
    endtask

    task automatic rd_clear(output int d);
        @(negedge clk);
        rd_addr = 4'd12; rd_en = 1'b1;
        #1 d = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (UIP + 1) @(negedge clk);
    endtask

    task automatic set_time(int h, int mi, int s, int dw, int dd, int mo, int yr,
                            bit bin, bit h24);
        int ctl = (bin ? 4 : 0) | (h24 ? 2 : 0);
        wr(11, 8'h80 | ctl);
        wr(0, enc(s, bin));  wr(2, enc(mi, bin)); wr(4, enc_h(h, bin, h24));
        wr(6, enc(dw, bin)); wr(7, enc(dd, bin)); wr(8, enc(mo, bin));
        wr(9, enc(yr, bin));
        wr(11, ctl);
    endtask

    task automatic check_time(string tag, int h, int mi, int s, int dw, int dd,
                              int mo, int yr, bit bin, bit h24);
        int d;
        rd(0, d); chk({tag, " sec"}, d, enc(s, bin));
        rd(2, d); chk({tag, " min"}, d, enc(mi, bin));
        rd(4, d); chk({tag, " hour"}, d, enc_h(h, bin, h24));
        rd(6, d); chk({tag, " wday"}, d, enc(dw, bin));
        rd(7, d); chk({tag, " day"}, d, enc(dd, bin));
        rd(8, d); chk({tag, " month"}, d, enc(mo, bin));
        rd(9, d); chk({tag, " year"}, d, enc(yr, bin));
    endtask

    task automatic model_next(inout int h, inout int mi, inout int s, inout int dw,
                              inout int dd, inout int mo, inout int yr);
        s++;
        if (s < 60) return;
        s = 0; mi++;
        if (mi < 60) return;
        mi = 0; h++;
        if (h < 24) return;
        h = 0; dw = (dw >= 7) ? 1 : dw + 1;
        dd++;
        if (dd <= dim(mo, yr)) return;
        dd = 1; mo++;
        if (mo <= 12) return;
        mo = 1; yr = (yr >= 99) ? 0 : yr + 1;
    endtask

    initial begin
        int d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_time("R1 reset", 0, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
        rd(10, d); chk("R1 ctl A", d, 8'h26);
        rd(11, d); chk("R1 ctl B", d, 8'h02);
        rd(12, d); chk("R1 flags", d, 8'h00);
        chk("R1 irq", int'(irq), 0);

        // R7 UIP timing
        @(negedge clk); rd_addr = 4'd10; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        #1 chk("R7 uip after strobe", int'(rd_data[7]), 1);
        repeat (UIP) @(negedge clk);
        #1 chk("R7 uip held", int'(rd_data[7]), 1);
        @(negedge clk);
        #1 chk("R7 uip cleared", int'(rd_data[7]), 0);
        rd(0, d); chk("R7 seconds refreshed", d, 8'h01);
        wr(10, 8'hA6); rd(10, d); chk("R7 uip not writable", d, 8'h26);

        // R2/R3 full rollover, BCD 24h
        set_time(23, 59, 59, 7, 31, 12, 99, 1'b0, 1'b1); tick();
        check_time("R2 R3 year wrap", 0, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
        // R3 leap rules
        set_time(23, 59, 59, 3, 28, 2, 0, 1'b0, 1'b1); tick();
        check_time("R3 leap 2000", 0, 0, 0, 4, 29, 2, 0, 1'b0, 1'b1);
        set_time(23, 59, 59, 3, 28, 2, 1, 1'b0, 1'b1); tick();
        check_time("R3 non-leap 2001", 0, 0, 0, 4, 1, 3, 1, 1'b0, 1'b1);
        set_time(23, 59, 59, 5, 30, 4, 7, 1'b1, 1'b1); tick();
        check_time("R3 R4 30-day binary", 0, 0, 0, 6, 1, 5, 7, 1'b1, 1'b1);
        // R5 12-hour noon crossing
        set_time(11, 59, 59, 2, 10, 6, 30, 1'b0, 1'b0); tick();
        rd(4, d); chk("R5 noon pm bit", d, 8'h80);
        set_time(22, 14, 9, 2, 10, 6, 30, 1'b1, 1'b0); tick();
        rd(4, d); chk("R5 R4 binary pm", d, 8'h8A);

        // R6 halted divider
        set_time(5, 6, 7, 1, 2, 3, 4, 1'b0, 1'b1);
        wr(10, 8'h06); tick();
        rd(0, d); chk("R6 no advance", d, 8'h07);
        rd(10, d); chk("R6 no uip", d, 8'h06);
        wr(10, 8'h26);

        // R8 SET freezes registers
        set_time(1, 2, 3, 1, 2, 3, 4, 1'b0, 1'b1);
        wr(11, 8'h92); rd(11, d); chk("R8 uie forced off", d, 8'h82);
        tick(); rd(0, d); chk("R8 frozen seconds", d, 8'h03);
        wr(0, 8'h40); rd(0, d); chk("R8 written under set", d, 8'h40);
        wr(11, 8'h02); tick();
        rd(0, d); chk("R8 loaded on release", d, 8'h41);
        rd(2, d); chk("R8 minutes kept", d, 8'h02);

        // R9 alarm with don't-care fields
        set_time(10, 20, 30, 1, 2, 3, 4, 1'b0, 1'b1);
        rd_clear(d);
        wr(1, 8'h31); wr(3, 8'hC0); wr(5, 8'hC0); wr(11, 8'h22);
        tick(); rd(12, d); chk("R9 alarm hit flags", d, 8'hB0);
        chk("R9 irq", int'(irq), 1);
        rd_clear(d); rd(12, d); chk("R11 flags cleared", d, 8'h00);
        chk("R11 irq dropped", int'(irq), 0);
        wr(1, 8'h45); tick();
        rd(12, d); chk("R9 R10 miss only UF", d, 8'h10);
        chk("R9 miss no irq", int'(irq), 0);
        // R10 update interrupt
        rd_clear(d); wr(11, 8'h12); tick();
        rd(12, d); chk("R10 UIE flags", d, 8'h90);
        chk("R10 irq", int'(irq), 1);
        rd_clear(d); wr(12, 8'hFF);
        rd(12, d); chk("R11 write ignored", d, 8'h00);
        wr(11, 8'h02);

        // random rollovers near boundaries (R2 R3 R4 R5)
        for (int it = 0; it < 40; it++) begin
            bit bin = 1'($urandom % 2);
            bit h24 = 1'($urandom % 2);
            int yr = int'($urandom % 100);
            int mo = 1 + int'($urandom % 12);
            int dd = ($urandom % 2) ? dim(mo, yr) : 1 + int'($urandom % 28);
            int dw = 1 + int'($urandom % 7);
            int h  = ($urandom % 2) ? 23 : int'($urandom % 24);
            int mi = ($urandom % 2) ? 59 : int'($urandom % 60);
            int s  = 55 + int'($urandom % 5);
            set_time(h, mi, s, dw, dd, mo, yr, bin, h24);
            tick();
            model_next(h, mi, s, dw, dd, mo, yr);
            check_time("R2 R3 R4 R5 random", h, mi, s, dw, dd, mo, yr, bin, h24);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule